// File: doc/BRIEF.md
# Cascadable Dual 16-bit Timer/Counter

The block holds two 16-bit count slices, A and B, each driven from a small word-addressed register interface. A slice either counts module-clock ticks or counts qualified activity on its own external pin. It runs up or down, and at its terminal value it either reloads and keeps going or halts. Software starts a slice with or without a fresh load from its reload register, stops it, and reads the live count back.

A concatenation bit in the control word of slice A fuses the pair into one 32-bit counter. In that mode slice A's control, run, reload and count addresses carry the whole pair: reload and count use the full 32-bit data word. Slice B advances only on the carry or borrow out of slice A.

Each slice has one bit in an interrupt enable register and one in a write-one-to-clear status register. The single `irq` output is the OR of the status bits whose enable is set. A timer counting down from reload value D in cyclic mode fires once every D+1 clocks, so a 16-bit divider covers periods up to 65536 clocks and the fused pair covers longer ones.

Top module: `tc_pair`

## Requirements
- R1: After a synchronous reset, every control, run, reload, count, enable and status register reads 0 and `irq` is low.
- R2: Register word addresses are 0/1 control A/B, 2/3 run A/B, 4/5 reload A/B, 6/7 count A/B, 8 interrupt enable and 9 interrupt status. `rd_data` returns the register selected by `reg_addr` one clock after that address was presented.
- R3: The control bits are as follows. Bit 0 reads the running state and ignores writes. Bit 1 set counts up. Bit 2 set selects counter mode. Bit 3 set halts at the terminal value instead of cycling. Bit 4 fuses the pair and exists in slice A only (it reads 0 in B). Bit 5 inverts the pin. Bits 7:6 select the event. Bit 8 selects the two-flop synchroniser. Bit 9 set makes timer mode count pin events. Bit 10 set makes counter mode count clock ticks instead of pin events.
- R4: In timer mode with bit 9 clear, a running slice changes by one on every clock. Counting down in cyclic mode from reload D, it reaches 0 and on the next clock reloads D and sets its status bit, giving a period of D+1 clocks.
- R5: In halt mode, on the clock where a count already at the terminal value (0xFFFF up, 0 down) would step, the count holds, running clears and the status bit is set.
- R6: In a run-register write, bit 0 starts the slice. When bit 2 is also set, the count is loaded from reload; otherwise the count resumes from its held value. Bit 1 stops the slice and wins over bit 0. A stopped slice holds its count. A stop write does not cancel a step on the same clock.
- R7: Event select in bits 7:6 has four values. 0 counts every clock the pin (after inversion) is high. 1 counts rising edges, 2 counts falling edges and 3 counts both. Inversion is applied before edge detection.
- R8: With the synchroniser selected, the pin passes through two flops before the edge detector; otherwise it passes through one. Both paths count the same number of events.
- R9: When fused, slice B steps only when slice A wraps. Reload and count at slice A addresses read and write {B,A} as 32 bits. Only status bit 0 can be set.
- R10: A status bit is set only when its enable bit is 1. Writing 1 to a status bit clears it, but a set on the same clock wins. `irq` is the registered OR of the enabled status bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| ext_in_a | input | 1 | External event pin for slice A |
| ext_in_b | input | 1 | External event pin for slice B |
| irq | output | 1 | Combined interrupt request |

## Verification
The checker assumes that registers are only written through `reg_wr`, so its step-size and hold properties skip the clock after any write. It also assumes that the fused bit is not toggled while counts are in flight; the stimulus reprograms control only while the slices are stopped. External pins are driven on the falling clock edge and held for at least two clocks per level. This keeps the one-flop path free of sub-cycle pulses and makes the expected edge count exact for both synchroniser settings.

// File: rtl/tc_pkg.sv
package tc_pkg;
  // Register word addresses
  localparam int A_CTRL_A = 0;
  localparam int A_CTRL_B = 1;
  localparam int A_RUN_A  = 2;
  localparam int A_RUN_B  = 3;
  localparam int A_RLD_A  = 4;
  localparam int A_RLD_B  = 5;
  localparam int A_CNT_A  = 6;
  localparam int A_CNT_B  = 7;
  localparam int A_IEN    = 8;
  localparam int A_IST    = 9;

  // Control word bit positions (bit 0 is the running state)
  localparam int B_UP   = 1;
  localparam int B_CNT  = 2;
  localparam int B_HALT = 3;
  localparam int B_CAT  = 4;
  localparam int B_INV  = 5;
  localparam int B_SYNC = 8;
  localparam int B_TEXT = 9;
  localparam int B_CINT = 10;

  // Run word bits
  localparam int R_GO   = 0;
  localparam int R_STOP = 1;
  localparam int R_LOAD = 2;

  typedef enum logic [1:0] {
    EV_LEVEL = 2'd0,
    EV_RISE  = 2'd1,
    EV_FALL  = 2'd2,
    EV_BOTH  = 2'd3
  } ev_sel_e;
endpackage

// File: rtl/tc_evt_qual.sv
module tc_evt_qual
  import tc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic       sync_en,
  input  logic       invert,
  input  logic [1:0] sel,
  output logic       evt
);
  logic st1, st2, prev;
  logic lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      st1  <= 1'b0;
      st2  <= 1'b0;
      prev <= 1'b0;
    end else begin
      st1  <= pin;
      st2  <= st1;
      prev <= lvl;
    end
  end

  assign lvl = (sync_en ? st2 : st1) ^ invert;

  always_comb begin
    unique case (ev_sel_e'(sel))
      EV_LEVEL: evt = lvl;
      EV_RISE:  evt = lvl & ~prev;
      EV_FALL:  evt = ~lvl & prev;
      default:  evt = lvl ^ prev;
    endcase
  end
endmodule

// File: rtl/tc_slice.sv
module tc_slice #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         up,
  output logic [W-1:0] count,
  output logic         at_end
);
  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else if (step) count <= up ? count + 1'b1 : count - 1'b1;
  end

  assign at_end = up ? (&count) : ~(|count);
endmodule

// File: rtl/tc_pair.sv
module tc_pair
  import tc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [2*CNT_W-1:0]   reg_wdata,
  output logic [2*CNT_W-1:0]   rd_data,
  input  logic                 ext_in_a,
  input  logic                 ext_in_b,
  output logic                 irq
);
  localparam int BUS_W = 2 * CNT_W;
  localparam int NH    = 2;

  logic [NH-1:0][10:1]      ctrl_q;
  logic [NH-1:0]            run_q;
  logic [NH-1:0][CNT_W-1:0] reload_q;
  logic [NH-1:0][CNT_W-1:0] cnt;
  logic [NH-1:0]            irq_en, irq_st;
  logic [NH-1:0]            st_n;

  logic [NH-1:0] ext_in, qev, src_ev, tick, at_end;
  logic [NH-1:0] ld, stp, hit, up_e, halt_e;
  logic [NH-1:0] wr_ctrl, wr_run, wr_rld, start_rl;
  logic          concat, wr_ien, wr_ist;

  assign ext_in = {ext_in_b, ext_in_a};
  assign concat = ctrl_q[0][B_CAT];

  // Address decode
  assign wr_ctrl[0] = reg_wr && (reg_addr == ADDR_W'(A_CTRL_A));
  assign wr_ctrl[1] = reg_wr && (reg_addr == ADDR_W'(A_CTRL_B));
  assign wr_run[0]  = reg_wr && (reg_addr == ADDR_W'(A_RUN_A));
  assign wr_run[1]  = reg_wr && (reg_addr == ADDR_W'(A_RUN_B));
  assign wr_rld[0]  = reg_wr && (reg_addr == ADDR_W'(A_RLD_A));
  assign wr_rld[1]  = reg_wr && (reg_addr == ADDR_W'(A_RLD_B));
  assign wr_ien     = reg_wr && (reg_addr == ADDR_W'(A_IEN));
  assign wr_ist     = reg_wr && (reg_addr == ADDR_W'(A_IST));

  // Per-slice input conditioning and count storage
  for (genvar h = 0; h < NH; h++) begin : g_half
    tc_evt_qual u_qual (
      .clk     (clk),
      .rst     (rst),
      .pin     (ext_in[h]),
      .sync_en (ctrl_q[h][B_SYNC]),
      .invert  (ctrl_q[h][B_INV]),
      .sel     (ctrl_q[h][7:6]),
      .evt     (qev[h])
    );

    assign src_ev[h] = ctrl_q[h][B_CNT] ? (ctrl_q[h][B_CINT] ? 1'b1 : qev[h])
                                        : (ctrl_q[h][B_TEXT] ? qev[h] : 1'b1);
    assign tick[h]     = run_q[h] & src_ev[h];
    assign start_rl[h] = wr_run[h] & reg_wdata[R_GO] & reg_wdata[R_LOAD] & ~reg_wdata[R_STOP];

    tc_slice #(.W(CNT_W)) u_slice (
      .clk      (clk),
      .rst      (rst),
      .load     (ld[h]),
      .load_val (reload_q[h]),
      .step     (stp[h]),
      .up       (up_e[h]),
      .count    (cnt[h]),
      .at_end   (at_end[h])
    );
  end

  // Terminal detection, cascade and load selection
  always_comb begin
    up_e[0]   = ctrl_q[0][B_UP];
    halt_e[0] = ctrl_q[0][B_HALT];
    up_e[1]   = concat ? ctrl_q[0][B_UP]   : ctrl_q[1][B_UP];
    halt_e[1] = concat ? ctrl_q[0][B_HALT] : ctrl_q[1][B_HALT];

    hit[0] = tick[0] & at_end[0] & (concat ? at_end[1] : 1'b1);
    stp[0] = tick[0] & ~hit[0];
    ld[0]  = start_rl[0] | (hit[0] & ~halt_e[0]);

    if (concat) begin
      hit[1] = 1'b0;
      stp[1] = tick[0] & at_end[0] & ~hit[0];
      ld[1]  = ld[0];
    end else begin
      hit[1] = tick[1] & at_end[1];
      stp[1] = tick[1] & ~hit[1];
      ld[1]  = start_rl[1] | (hit[1] & ~halt_e[1]);
    end

    st_n = (irq_st & ~(wr_ist ? reg_wdata[NH-1:0] : '0)) | (hit & irq_en);
  end

  // Register state
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      run_q    <= '0;
      reload_q <= '0;
      irq_en   <= '0;
      irq_st   <= '0;
      irq      <= 1'b0;
    end else begin
      if (wr_ctrl[0]) ctrl_q[0] <= reg_wdata[10:1];
      if (wr_ctrl[1]) ctrl_q[1] <= {reg_wdata[10:5], 1'b0, reg_wdata[3:1]};

      for (int h = 0; h < NH; h++) begin
        if (wr_run[h] && reg_wdata[R_STOP])     run_q[h] <= 1'b0;
        else if (wr_run[h] && reg_wdata[R_GO])  run_q[h] <= 1'b1;
        else if (hit[h] && halt_e[h])           run_q[h] <= 1'b0;
      end

      if (wr_rld[0]) begin
        reload_q[0] <= reg_wdata[CNT_W-1:0];
        if (concat) reload_q[1] <= reg_wdata[BUS_W-1:CNT_W];
      end
      if (wr_rld[1] && !concat) reload_q[1] <= reg_wdata[CNT_W-1:0];

      if (wr_ien) irq_en <= reg_wdata[NH-1:0];
      irq_st <= st_n;
      irq    <= |(st_n & (wr_ien ? reg_wdata[NH-1:0] : irq_en));
    end
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      unique case (reg_addr)
        ADDR_W'(A_CTRL_A): rd_data <= BUS_W'({ctrl_q[0], run_q[0]});
        ADDR_W'(A_CTRL_B): rd_data <= BUS_W'({ctrl_q[1], run_q[1]});
        ADDR_W'(A_RLD_A):  rd_data <= concat ? {reload_q[1], reload_q[0]} : BUS_W'(reload_q[0]);
        ADDR_W'(A_RLD_B):  rd_data <= BUS_W'(reload_q[1]);
        ADDR_W'(A_CNT_A):  rd_data <= concat ? {cnt[1], cnt[0]} : BUS_W'(cnt[0]);
        ADDR_W'(A_CNT_B):  rd_data <= BUS_W'(cnt[1]);
        ADDR_W'(A_IEN):    rd_data <= BUS_W'(irq_en);
        ADDR_W'(A_IST):    rd_data <= BUS_W'(irq_st);
        default:           rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tc_pair_chk.sv
module tc_pair_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic             run_a,
  input logic             concat,
  input logic [CNT_W-1:0] cnt_a,
  input logic [CNT_W-1:0] reload_a,
  input logic [1:0]       irq_en,
  input logic [1:0]       irq_st
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt_a == '0 && irq_st == 2'b00 && !run_a));

  // R4
  step_size_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(run_a) && !$past(reg_wr) && !$past(concat)) |->
      (cnt_a == $past(cnt_a) || cnt_a == $past(cnt_a) + 1'b1 ||
       cnt_a == $past(cnt_a) - 1'b1 || cnt_a == $past(reload_a)));

  // R6
  stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_a && !$past(run_a) && !$past(reg_wr)) |-> $stable(cnt_a));

  // R10
  status_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_st[0] && !$past(irq_st[0])) |-> $past(irq_en[0]));

  // R10
  status_gate_b_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_st[1] && !$past(irq_st[1])) |-> $past(irq_en[1]));

  // R9
  fused_no_b_chk: assert property (@(posedge clk) disable iff (rst)
    (concat && $past(concat)) |-> !(irq_st[1] && !$past(irq_st[1])));
endmodule

bind tc_pair tc_pair_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_wr   (reg_wr),
  .run_a    (run_q[0]),
  .concat   (concat),
  .cnt_a    (cnt[0]),
  .reload_a (reload_q[0]),
  .irq_en   (irq_en),
  .irq_st   (irq_st)
);

// File: tb/tc_pair_test.sv
module tc_pair_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rd_data;
  logic        ext_in_a = 1'b0;
  logic        ext_in_b = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t sb[$];
  exp_t cur;

  always #2.5 clk = ~clk;

  tc_pair uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_data(rd_data),
    .ext_in_a(ext_in_a), .ext_in_b(ext_in_b), .irq(irq)
  );

  // Monitor: compare registered read data against queued expectations
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      cur = sb.pop_front();
      n_chk++;
      if (rd_data !== cur.exp) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", cur.tag, rd_data, cur.exp);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // Driver: present address, push the expected value once the read register has loaded
  task automatic rd_exp(input logic [3:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    reg_addr = a;
    @(posedge clk);
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq && n < 150000);
  endtask

  task automatic pulse_a(input int n);
    for (int i = 0; i < n; i++) begin
      ext_in_a = 1'b1; idle(2);
      ext_in_a = 1'b0; idle(2);
    end
  endtask

  task automatic run_pulses(input logic [31:0] ctl, input int n, input logic [31:0] e, input string tag);
    wr(4'd0, ctl);
    wr(4'd2, 32'h5);
    idle(2);
    pulse_a(n);
    idle(4);
    wr(4'd2, 32'h2);
    rd_exp(4'd6, e, tag);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int n;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state, R2 one-cycle read latency
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    rd_exp(4'd0, 32'h0, "R1 ctrl A");
    rd_exp(4'd6, 32'h0, "R1 count A");
    rd_exp(4'd9, 32'h0, "R1 status");
    rd_exp(4'd4, 32'h0, "R2 reload A latency");

    // R4 down cyclic timer, reload 5 -> period 6
    wr(4'd0, 32'h0);
    wr(4'd4, 32'd5);
    wr(4'd8, 32'h1);
    wr(4'd2, 32'h5);
    wait_irq(n);
    chk(n == 6, "R4 first period", n, 6);
    wr(4'd9, 32'h1);
    chk(irq == 1'b0, "R10 write-one-to-clear", irq, 0);
    wait_irq(n);
    chk(n == 5, "R4 cyclic reload continues", n, 5);
    wr(4'd2, 32'h2);
    wr(4'd9, 32'h1);

    // R5 halt mode counting up from 0xFFFC
    wr(4'd0, 32'h0A);
    wr(4'd4, 32'hFFFC);
    wr(4'd2, 32'h5);
    idle(10);
    rd_exp(4'd6, 32'hFFFF, "R5 count held at terminal");
    rd_exp(4'd0, 32'h0A, "R5 running cleared, R3 fields read back");
    rd_exp(4'd9, 32'h1, "R5 status set");
    chk(irq == 1'b1, "R10 irq from enabled status", irq, 1);
    wr(4'd9, 32'h1);

    // R10 gating: slice B halts with its enable off
    wr(4'd8, 32'h0);
    wr(4'd1, 32'h1A);
    wr(4'd5, 32'hFFFE);
    wr(4'd3, 32'h5);
    idle(8);
    rd_exp(4'd9, 32'h0, "R10 status blocked when disabled");
    rd_exp(4'd1, 32'h0A, "R3 slice B has no fuse bit");
    chk(irq == 1'b0, "R10 irq low", irq, 0);

    // R6 start-with-load, resume and stop priority on slice B
    wr(4'd1, 32'h0);
    wr(4'd5, 32'd100);
    wr(4'd3, 32'h5);
    wr(4'd3, 32'h2);
    rd_exp(4'd7, 32'd99, "R6 load then one step");
    wr(4'd3, 32'h1);
    wr(4'd3, 32'h2);
    rd_exp(4'd7, 32'd98, "R6 resume keeps count");
    wr(4'd3, 32'h3);
    idle(3);
    rd_exp(4'd7, 32'd98, "R6 stop wins over start");
    rd_exp(4'd1, 32'h0, "R6 running stays clear");

    // R7 / R8 counter mode event selection on slice A
    wr(4'd4, 32'h0);
    run_pulses(32'h046, 4, 32'd4, "R7 rising edges");
    run_pulses(32'h086, 4, 32'd4, "R7 falling edges");
    run_pulses(32'h0C6, 4, 32'd8, "R7 both edges");
    run_pulses(32'h066, 3, 32'd3, "R7 inverted rising");
    run_pulses(32'h146, 5, 32'd5, "R8 synchronised rising");
    run_pulses(32'h242, 3, 32'd3, "R3 timer mode external source");

    // R7 level mode through the synchroniser: 7 clocks high -> 7
    wr(4'd0, 32'h106);
    wr(4'd2, 32'h5);
    idle(3);
    ext_in_a = 1'b1; idle(7);
    ext_in_a = 1'b0; idle(5);
    wr(4'd2, 32'h2);
    rd_exp(4'd6, 32'd7, "R7 level counting");

    // R3 counter mode with internal tick source
    wr(4'd0, 32'h406);
    wr(4'd2, 32'h5);
    wr(4'd2, 32'h2);
    rd_exp(4'd6, 32'd1, "R3 counter internal source");

    // R9 fused pair: carry from A into B
    wr(4'd0, 32'h12);
    wr(4'd4, 32'h0000FFFE);
    rd_exp(4'd4, 32'h0000FFFE, "R9 32-bit reload read");
    wr(4'd2, 32'h5);
    wr(4'd2, 32'h2);
    rd_exp(4'd6, 32'h0000FFFF, "R9 low half step");
    wr(4'd2, 32'h1);
    wr(4'd2, 32'h2);
    rd_exp(4'd6, 32'h00010000, "R9 carry into upper half");

    // R9 fused 32-bit down period: reload 0x10002 -> 65539 clocks
    wr(4'd0, 32'h10);
    wr(4'd4, 32'h00010002);
    wr(4'd9, 32'h3);
    wr(4'd8, 32'h3);
    wr(4'd2, 32'h5);
    wait_irq(n);
    chk(n == 65539, "R9 fused period", n, 65539);
    wr(4'd2, 32'h2);
    rd_exp(4'd9, 32'h1, "R9 only status bit 0");

    idle(2);
    summary();
    $finish;
  end
endmodule